// File: doc/BRIEF.md
# Two-Port Memory Host Arbiter

This block lets two independent clients share one memory-controller host interface. It sits between the controller and two client ports. Each client port carries the same signals and follows the same handshake as the controller's own host interface. A client that was wired straight to the controller can therefore be moved onto either port unchanged. A client raises a read or write request together with an address and, for writes, the data. It holds them until it sees a one-cycle done strobe. On that strobe, read data is valid for a read.

Controller bandwidth is shared through a fixed slot pattern given as a parameter, with one bit per slot. A slot whose bit is 0 belongs to port 0 and a slot whose bit is 1 belongs to port 1. The pattern can favour either port. The slot pointer moves forward once per completed operation and wraps at the end of the pattern. If the owner of the current slot is idle while the other port is waiting, the other port is served, so no slot is wasted. The controller side follows the same handshake as a client port. One instance can therefore drive a port of another instance, which gives three or more clients.

Top module: `hostport_split2`

## Requirements
- R1: While reset is held and on the first cycle after it, both client busy flags are 0, both done strobes are 0, both client read-data words are zero, and the controller read and write requests are 0.
- R2: From the cycle after a grant until the controller reports done, the controller address, write data and read/write requests equal the values the served port presented when it was granted. Read and write are never requested together (write wins if a client raises both).
- R3: When both ports have requests waiting at every arbitration, the k-th completed operation belongs to port SLOT_MAP[k mod SLOTS]. Bit value 0 means port 0 and bit value 1 means port 1.
- R4: A request is served even when the current slot belongs to the other port and that port is idle. A lone client finishes each operation within controller latency plus 4 cycles.
- R5: Only one operation is in flight. The controller request stays asserted until the controller's done, and is dropped on the clock edge at which done is seen.
- R6: Each completed operation produces exactly one one-cycle done pulse, on the port that issued it. The two done strobes are never high together.
- R7: On a read's done pulse, that port's read data equals the word last written to that address. A port's read data changes only in a cycle where its own read completes and otherwise holds its value.
- R8: Both busy flags are high while a controller request is asserted and while the controller reports busy.
- R9: The slot pointer advances only on completed operations. Its position carries across idle periods and single-port traffic, and the R3 ordering continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl_rd | input | 2 | Read request per port, held until done |
| cl_wr | input | 2 | Write request per port, held until done |
| cl_addr | input | 2xAW | Address per port |
| cl_wdata | input | 2xDW | Write data per port |
| cl_rdata | output | 2xDW | Read data per port, valid with done |
| cl_done | output | 2 | One-cycle completion strobe per port |
| cl_busy | output | 2 | Per-port busy flag |
| mc_rd | output | 1 | Read request to controller |
| mc_wr | output | 1 | Write request to controller |
| mc_addr | output | AW | Address to controller |
| mc_wdata | output | DW | Write data to controller |
| mc_rdata | input | DW | Read data from controller |
| mc_done | input | 1 | Controller completion strobe |
| mc_busy | input | 1 | Controller busy flag |

## Verification
The two functions that meet in one cycle are a completion on one port and a pending request on the other port. The other port's new request competes with the completing port's follow-up request at the very next arbitration. The bench makes both clients reload a new operation in the same cycle their done arrives, so both ports are always pending. Every completion is then compared with the slot pattern at a tracked slot index. In the same cycle, the idle port's done strobe and read data are checked against the values held from its last completion, and the controller-side request is matched to the client it came from.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_RUN  = 2'd1,
    HS_RESP = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hsp_slot_pick.sv
module hsp_slot_pick #(
  parameter int SLOTS = 8,
  parameter logic [SLOTS-1:0] SLOT_MAP = '0,
  parameter int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SW-1:0] slot,
  input  logic [1:0]    req,
  output logic          pick_v,
  output logic          pick_p
);
  logic owner;

  always_comb begin
    owner  = SLOT_MAP[slot];
    pick_v = |req;
    // slot owner first; the other port takes an otherwise empty slot
    pick_p = req[owner] ? owner : ~owner;
  end
endmodule

// File: rtl/hsp_req_mux.sv
module hsp_req_mux #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic                 sel,
  input  logic [1:0]           cl_rd,
  input  logic [1:0]           cl_wr,
  input  logic [1:0][AW-1:0]   cl_addr,
  input  logic [1:0][DW-1:0]   cl_wdata,
  output logic                 rd,
  output logic                 wr,
  output logic [AW-1:0]        addr,
  output logic [DW-1:0]        wdata
);
  always_comb begin
    wr    = cl_wr[sel];
    rd    = cl_rd[sel] & ~cl_wr[sel];
    addr  = cl_addr[sel];
    wdata = cl_wdata[sel];
  end
endmodule

// File: rtl/hsp_resp_route.sv
module hsp_resp_route #(
  parameter int DW = 16,
  parameter int NP = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic                port,
  input  logic                is_rd,
  input  logic [DW-1:0]       mc_rdata,
  output logic [NP-1:0]       done,
  output logic [NP-1:0][DW-1:0] rdata
);
  for (genvar i = 0; i < NP; i++) begin : g_port
    logic hit;
    assign hit = fire && (int'(port) == i);

    always_ff @(posedge clk) begin
      if (rst) begin
        done[i]  <= 1'b0;
        rdata[i] <= '0;
      end else begin
        done[i] <= hit;
        if (hit && is_rd) rdata[i] <= mc_rdata;
      end
    end
  end
endmodule

// File: rtl/hostport_split2.sv
module hostport_split2 #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int SLOTS = 8,
  parameter logic [SLOTS-1:0] SLOT_MAP = 8'b0110_1110
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cl_rd,
  input  logic [1:0]         cl_wr,
  input  logic [1:0][AW-1:0] cl_addr,
  input  logic [1:0][DW-1:0] cl_wdata,
  output logic [1:0][DW-1:0] cl_rdata,
  output logic [1:0]         cl_done,
  output logic [1:0]         cl_busy,
  output logic               mc_rd,
  output logic               mc_wr,
  output logic [AW-1:0]      mc_addr,
  output logic [DW-1:0]      mc_wdata,
  input  logic [DW-1:0]      mc_rdata,
  input  logic               mc_done,
  input  logic               mc_busy
);
  import hsp_pkg::*;

  localparam int NP = 2;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  hs_state_e     state;
  logic [SW-1:0] slot;
  logic          gnt;
  logic          pick_v, pick_p;
  logic          sel_rd, sel_wr;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic          fire;

  hsp_slot_pick #(.SLOTS(SLOTS), .SLOT_MAP(SLOT_MAP), .SW(SW)) u_pick (
    .slot   (slot),
    .req    (cl_rd | cl_wr),
    .pick_v (pick_v),
    .pick_p (pick_p)
  );

  hsp_req_mux #(.AW(AW), .DW(DW)) u_mux (
    .sel      (pick_p),
    .cl_rd    (cl_rd),
    .cl_wr    (cl_wr),
    .cl_addr  (cl_addr),
    .cl_wdata (cl_wdata),
    .rd       (sel_rd),
    .wr       (sel_wr),
    .addr     (sel_addr),
    .wdata    (sel_wdata)
  );

  assign fire = (state == HS_RUN) && mc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= HS_IDLE;
      slot     <= '0;
      gnt      <= 1'b0;
      mc_rd    <= 1'b0;
      mc_wr    <= 1'b0;
      mc_addr  <= '0;
      mc_wdata <= '0;
    end else begin
      unique case (state)
        HS_IDLE: begin
          if (pick_v && !mc_busy) begin
            gnt      <= pick_p;
            mc_rd    <= sel_rd;
            mc_wr    <= sel_wr;
            mc_addr  <= sel_addr;
            mc_wdata <= sel_wdata;
            state    <= HS_RUN;
          end
        end
        HS_RUN: begin
          if (mc_done) begin
            mc_rd <= 1'b0;
            mc_wr <= 1'b0;
            slot  <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
            state <= HS_RESP;
          end
        end
        HS_RESP: state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end

  hsp_resp_route #(.DW(DW), .NP(NP)) u_route (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .port     (gnt),
    .is_rd    (mc_rd),
    .mc_rdata (mc_rdata),
    .done     (cl_done),
    .rdata    (cl_rdata)
  );

  assign cl_busy = {NP{(state != HS_IDLE) || mc_busy}};
endmodule

// File: rtl/hostport_split2_chk.sv
module hostport_split2_chk #(
  parameter int DW = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         cl_done,
  input logic [1:0][DW-1:0] cl_rdata,
  input logic [1:0]         cl_busy,
  input logic               mc_rd,
  input logic               mc_wr,
  input logic               mc_done,
  input logic               mc_busy
);
  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cl_done));
  // R6
  done0_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cl_done[0] |=> !cl_done[0]);
  // R6
  done1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cl_done[1] |=> !cl_done[1]);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mc_rd || mc_wr) && !mc_done) |=> (mc_rd || mc_wr));
  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    mc_done |=> (!mc_rd && !mc_wr));
  // R2
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mc_rd && mc_wr));
  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_rd || mc_wr || mc_busy) |-> (&cl_busy));
  // R7
  rdata0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cl_done[0] |-> $stable(cl_rdata[0]));
  // R7
  rdata1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cl_done[1] |-> $stable(cl_rdata[1]));
endmodule

bind hostport_split2 hostport_split2_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cl_done  (cl_done),
  .cl_rdata (cl_rdata),
  .cl_busy  (cl_busy),
  .mc_rd    (mc_rd),
  .mc_wr    (mc_wr),
  .mc_done  (mc_done),
  .mc_busy  (mc_busy)
);

// File: tb/sim_hostport_split2.sv
`timescale 1ns/1ps
module sim_hostport_split2;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SLOTS = 8;
  localparam logic [SLOTS-1:0] MAP = 8'b0110_1110;
  localparam int LAT = 3;
  localparam int MAXOPS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]         cl_rd = '0, cl_wr = '0;
  logic [1:0][AW-1:0] cl_addr = '0;
  logic [1:0][DW-1:0] cl_wdata = '0;
  logic [1:0][DW-1:0] cl_rdata;
  logic [1:0]         cl_done, cl_busy;
  logic               mc_rd, mc_wr;
  logic [AW-1:0]      mc_addr;
  logic [DW-1:0]      mc_wdata;
  logic [DW-1:0]      mc_rdata;
  logic               mc_done, mc_busy;

  hostport_split2 #(.AW(AW), .DW(DW), .SLOTS(SLOTS), .SLOT_MAP(MAP)) u0 (
    .clk(clk), .rst(rst), .cl_rd(cl_rd), .cl_wr(cl_wr), .cl_addr(cl_addr),
    .cl_wdata(cl_wdata), .cl_rdata(cl_rdata), .cl_done(cl_done),
    .cl_busy(cl_busy), .mc_rd(mc_rd), .mc_wr(mc_wr), .mc_addr(mc_addr),
    .mc_wdata(mc_wdata), .mc_rdata(mc_rdata), .mc_done(mc_done),
    .mc_busy(mc_busy)
  );

  // behavioural memory controller
  logic [DW-1:0] mem [256];
  int            mcnt;
  logic [AW-1:0] m_a;
  logic          m_w;
  logic [DW-1:0] m_d;
  always @(posedge clk) begin
    if (rst) begin
      mc_done <= 1'b0; mc_busy <= 1'b0; mc_rdata <= '0; mcnt <= 0;
    end else begin
      mc_done <= 1'b0;
      if (mcnt == 0) begin
        if ((mc_rd || mc_wr) && !mc_done) begin
          mcnt <= LAT; mc_busy <= 1'b1;
          m_a <= mc_addr; m_w <= mc_wr; m_d <= mc_wdata;
        end
      end else begin
        mcnt <= mcnt - 1;
        if (mcnt == 1) begin
          mc_done <= 1'b1; mc_busy <= 1'b0;
          if (m_w) mem[m_a] <= m_d; else mc_rdata <= mem[m_a];
        end
      end
    end
  end

  // bench bookkeeping
  int n_chk = 0, n_fail = 0;
  int nops [2];
  logic op_w [2][MAXOPS];
  logic [AW-1:0] op_a [2][MAXOPS];
  logic [DW-1:0] op_d [2][MAXOPS];
  int ptr [2];
  bit act [2];
  bit en [2];
  logic [DW-1:0] last_rd [2];
  logic [DW-1:0] refmem [256];
  int exp_slot = 0;
  int owner = -1;
  bit prev_req = 1'b0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_run();
    end
  end

  // per-clock reference model, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(!(cl_done[0] && cl_done[1]), "R6", "both done", cl_done, 0);
      if (mc_rd || mc_wr || mc_busy)
        chk(cl_busy == 2'b11, "R8", "busy during op", cl_busy, 3);
      chk(!(mc_rd && mc_wr), "R2", "rd and wr together", {mc_rd, mc_wr}, 0);
      if ((mc_rd || mc_wr) && !prev_req) begin
        owner = -1;
        for (int i = 0; i < 2; i++)
          if (act[i] && op_a[i][ptr[i]] == mc_addr) owner = i;
        chk(owner >= 0, "R2", "controller addr matches a client", mc_addr, 0);
        if (owner >= 0) begin
          chk(mc_wr == op_w[owner][ptr[owner]], "R2", "write flag", mc_wr,
              op_w[owner][ptr[owner]]);
          if (mc_wr)
            chk(mc_wdata == op_d[owner][ptr[owner]], "R2", "write data",
                mc_wdata, op_d[owner][ptr[owner]]);
        end
      end
      prev_req = mc_rd || mc_wr;
      for (int i = 0; i < 2; i++) begin
        if (cl_done[i]) begin
          chk(act[i], "R6", "done without request", i, 0);
          chk(owner == i, "R6", "done on wrong port", i, owner);
          // both continuously pending: order follows the slot map
          if (act[0] && act[1] && en[0] && en[1])
            chk(i == int'(MAP[exp_slot % SLOTS]), "R3/R9", "slot order", i,
                MAP[exp_slot % SLOTS]);
          exp_slot++;
          if (act[i]) begin
            if (op_w[i][ptr[i]]) refmem[op_a[i][ptr[i]]] = op_d[i][ptr[i]];
            else chk(cl_rdata[i] == refmem[op_a[i][ptr[i]]], "R7",
                     "read data", cl_rdata[i], refmem[op_a[i][ptr[i]]]);
            ptr[i]++;
          end
          act[i] = 1'b0; cl_rd[i] = 1'b0; cl_wr[i] = 1'b0;
          last_rd[i] = cl_rdata[i];
        end else begin
          chk(cl_rdata[i] == last_rd[i], "R7", "idle port rdata held",
              cl_rdata[i], last_rd[i]);
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (!act[i] && en[i] && ptr[i] < nops[i]) begin
          act[i] = 1'b1;
          cl_rd[i] = ~op_w[i][ptr[i]];
          cl_wr[i] = op_w[i][ptr[i]];
          cl_addr[i] = op_a[i][ptr[i]];
          cl_wdata[i] = op_d[i][ptr[i]];
        end
      end
    end
  end

  task automatic setup(input int p, input int n, input bit w, input int base,
                       input int seed);
    for (int k = 0; k < n; k++) begin
      op_w[p][k] = w;
      op_a[p][k] = AW'(base + k);
      op_d[p][k] = DW'((seed * 37 + k * 113) ^ (k << 9));
    end
    nops[p] = n; ptr[p] = 0;
  endtask

  task automatic run(input bit e0, input bit e1, output int took);
    int t0;
    @(negedge clk);
    t0 = cyc;
    en[0] = e0; en[1] = e1;
    while ((e0 && ptr[0] < nops[0]) || (e1 && ptr[1] < nops[1]) ||
           act[0] || act[1]) @(negedge clk);
    took = cyc - t0;
    en[0] = 1'b0; en[1] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int took;
    for (int a = 0; a < 256; a++) begin mem[a] = '0; refmem[a] = '0; end
    nops[0] = 0; nops[1] = 0; ptr[0] = 0; ptr[1] = 0;
    act[0] = 0; act[1] = 0; en[0] = 0; en[1] = 0;
    last_rd[0] = '0; last_rd[1] = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cl_busy == 2'b00 && cl_done == 2'b00, "R1", "flags in reset",
        {cl_busy, cl_done}, 0);
    chk(cl_rdata == '0, "R1", "rdata in reset", cl_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mc_rd && !mc_wr && cl_busy == 2'b00, "R1", "after reset",
        {mc_rd, mc_wr, cl_busy}, 0);

    // both ports write to separate regions, then read back
    setup(0, 12, 1'b1, 8'h00, 1);
    setup(1, 12, 1'b1, 8'h80, 2);
    run(1, 1, took);
    chk(ptr[0] == 12 && ptr[1] == 12, "R3", "writes completed", ptr[0] + ptr[1], 24);
    setup(0, 12, 1'b0, 8'h00, 1);
    setup(1, 12, 1'b0, 8'h80, 2);
    run(1, 1, took);
    chk(ptr[0] == 12 && ptr[1] == 12, "R7", "reads completed", ptr[0] + ptr[1], 24);

    // lone client on slots owned by the other port
    setup(1, 4, 1'b0, 8'h80, 2);
    run(0, 1, took);
    chk(ptr[1] == 4, "R4", "lone port1 served", ptr[1], 4);
    chk(took <= 4 * (LAT + 4) + 6, "R4", "lone port1 latency", took, 4 * (LAT + 4) + 6);
    setup(0, 5, 1'b1, 8'h20, 7);
    run(1, 0, took);
    chk(ptr[0] == 5, "R4", "lone port0 served", ptr[0], 5);
    chk(took <= 5 * (LAT + 4) + 6, "R4", "lone port0 latency", took, 5 * (LAT + 4) + 6);

    // mixed traffic; slot order resumes from the advanced pointer (R9)
    setup(0, 10, 1'b0, 8'h20, 7);
    setup(1, 10, 1'b1, 8'hC0, 9);
    op_w[0][7] = 1'b1; op_a[0][7] = 8'h40; op_d[0][7] = 16'hBEEF;
    op_w[0][8] = 1'b0; op_a[0][8] = 8'h40;
    run(1, 1, took);
    chk(ptr[0] == 10 && ptr[1] == 10, "R9", "mixed completed", ptr[0] + ptr[1], 20);
    chk(cl_rdata[0] == refmem[op_a[0][9]], "R7", "final port0 rdata",
        cl_rdata[0], refmem[op_a[0][9]]);
    finish_run();
  end
endmodule